// File: doc/BRIEF.md
# Sixteen-Channel Interrupt Collector

This block merges the level interrupt requests of sixteen serial channels into a single interrupt line toward the host. Each channel drives one request input that stays high while the channel needs service. The block does not create these requests. It only filters and combines them.

Two controls sit between the channels and the output. The first is a per-channel mask with inverted polarity: a one in a mask bit blocks that channel, and a zero lets it pass. The second is a single global enable bit. Reset blocks every channel and clears the global enable, so software must open both before any request reaches the host. A small word-addressed register port lets software write the mask and the enable, and read them back. The same port reads the unfiltered channel requests. The interrupt output is a flop and follows its inputs one clock later.

Top module: `cirq_collector`

## Requirements
- R1: After reset, every mask bit reads 1, the global enable reads 0 and `irq_out` is low.
- R2: A read at word address 0 returns the live channel requests in bits 15:0 (bit n is channel n) and zero above, whatever the mask and enable hold.
- R3: A write at word address 1 loads bits 15:0 into the mask on that clock edge. A read at address 1 returns the mask in bits 15:0 and zero above.
- R4: A write at word address 2 loads bit 20 into the global enable, and the other bits have no effect. A read at address 2 returns the enable in bit 20 and zero in every other bit.
- R5: A channel whose mask bit is 1 cannot raise `irq_out`, even while its request is high and the global enable is 1.
- R6: `irq_out` is high in a cycle exactly when, at the previous clock edge, the global enable was 1 and at least one channel had its request high with its mask bit 0.
- R7: While the global enable is 0, `irq_out` stays low for every combination of requests and mask.
- R8: Writes to word address 0 (status) and address 3 (unused) leave the mask and the enable unchanged. Reads at address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | 16 | Level interrupt requests, one per channel |
| bus_addr | input | 2 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr` |
| irq_out | output | 1 | Combined interrupt toward the host |

## Verification
The merge is first tried with requests present while all channels are still blocked, and then while the global enable is clear. These two patterns separate the effect of the mask from the effect of the enable. A walk opens one channel at a time and raises either that channel's request or a neighbour's request, which exposes any bit that is swapped, inverted or tied between channels. Writes to the status word and to the unused word, followed by readback of the mask and the enable, show whether the address decode leaks into the control state. A cycle-level model in the bench checks the one-clock output latency and every read word on each clock.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
   // word indices of the register port; the decode order is fixed
   localparam int unsigned WORD_STAT = 0;
   localparam int unsigned WORD_MASK = 1;
   localparam int unsigned WORD_CTRL = 2;
endpackage

// File: rtl/cirq_regs.sv
module cirq_regs
   import cirq_pkg::*;
#(
   parameter int unsigned NUM_CHAN = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned EN_BIT   = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_CHAN-1:0] mask_q,
   output logic                gen_en_q
);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(WORD_MASK);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WORD_CTRL);

   logic hit_mask, hit_ctrl;
   assign hit_mask = wr && (addr == A_MASK);
   assign hit_ctrl = wr && (addr == A_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= '1;
         gen_en_q <= 1'b0;
      end else begin
         if (hit_mask) mask_q   <= wdata[NUM_CHAN-1:0];
         if (hit_ctrl) gen_en_q <= wdata[EN_BIT];
      end
   end

   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_MASK) |=> (mask_q == $past(wdata[NUM_CHAN-1:0])));

   // R8
   ro_write_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr != A_MASK && addr != A_CTRL) |=> ($stable(mask_q) && $stable(gen_en_q)));
endmodule

// File: rtl/cirq_merge.sv
module cirq_merge #(
   parameter int unsigned NUM_CHAN = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CHAN-1:0] req,
   input  logic [NUM_CHAN-1:0] mask,
   input  logic                gen_en,
   output logic [NUM_CHAN-1:0] pend,
   output logic                irq_q
);
   genvar ch;
   generate
      for (ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
         // a set mask bit blocks the channel
         assign pend[ch] = req[ch] & ~mask[ch];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= gen_en & (|pend);
   end
endmodule

// File: rtl/cirq_rdmux.sv
module cirq_rdmux
   import cirq_pkg::*;
#(
   parameter int unsigned NUM_CHAN  = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned EN_BIT    = 20,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [NUM_CHAN-1:0] req,
   input  logic [NUM_CHAN-1:0] mask,
   input  logic                gen_en,
   output logic [DATA_W-1:0]   rdata
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WORD_STAT);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(WORD_MASK);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WORD_CTRL);

   logic [DATA_W-1:0] word;

   always_comb begin
      word = '0;
      if (addr == A_STAT)      word[NUM_CHAN-1:0] = req;
      else if (addr == A_MASK) word[NUM_CHAN-1:0] = mask;
      else if (addr == A_CTRL) word[EN_BIT]       = gen_en;
   end

   generate
      if (RDATA_REG) begin : g_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= word;
         end
         assign rdata = rd_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rdata = word;
      end
   endgenerate
endmodule

// File: rtl/cirq_collector.sv
module cirq_collector
   import cirq_pkg::*;
#(
   parameter int unsigned NUM_CHAN  = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned EN_BIT    = 20,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CHAN-1:0] chan_req,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_out
);
   generate
      if (NUM_CHAN < 1 || NUM_CHAN > DATA_W) begin : g_bad_chan
         $error("cirq_collector: NUM_CHAN must lie in 1..DATA_W");
      end
      if (EN_BIT >= DATA_W || EN_BIT < NUM_CHAN) begin : g_bad_en
         $error("cirq_collector: EN_BIT must sit above the channel field inside the word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("cirq_collector: ADDR_W must cover three register words");
      end
   endgenerate

   logic [NUM_CHAN-1:0] mask;
   logic [NUM_CHAN-1:0] pend;
   logic                gen_en;

   cirq_regs #(
      .NUM_CHAN (NUM_CHAN),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .EN_BIT   (EN_BIT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .mask_q   (mask),
      .gen_en_q (gen_en)
   );

   cirq_merge #(
      .NUM_CHAN (NUM_CHAN)
   ) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (chan_req),
      .mask     (mask),
      .gen_en   (gen_en),
      .pend     (pend),
      .irq_q    (irq_out)
   );

   cirq_rdmux #(
      .NUM_CHAN  (NUM_CHAN),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .EN_BIT    (EN_BIT),
      .RDATA_REG (RDATA_REG)
   ) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .req      (chan_req),
      .mask     (mask),
      .gen_en   (gen_en),
      .rdata    (bus_rdata)
   );

   // R7
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(gen_en) |-> !irq_out);

   // R5
   all_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(&mask) |-> !irq_out);

   // R6
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(pend != '0));

   // R6
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gen_en && (pend != '0)) |-> irq_out);
endmodule

// File: tb/cirq_collector_bench.sv
module cirq_collector_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] chan_req = '0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   cirq_collector u_cirq_collector (
      .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   // behavioural reference
   logic [15:0] m_block;
   bit          m_on;
   bit          m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_block <= 16'hFFFF;
         m_on    <= 1'b0;
         m_irq   <= 1'b0;
      end else begin
         bit any;
         any = 1'b0;
         for (int k = 0; k < 16; k++) if (chan_req[k] && !m_block[k]) any = 1'b1;
         m_irq <= m_on && any;
         if (bus_wr && bus_addr == 2'd1) m_block <= bus_wdata[15:0];
         if (bus_wr && bus_addr == 2'd2) m_on <= bus_wdata[20];
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         logic [31:0] w;
         check("R6 irq", {31'd0, irq_out}, {31'd0, m_irq});
         case (bus_addr)
            2'd0: begin w = {16'd0, chan_req}; check("R2 rd", bus_rdata, w); end
            2'd1: begin w = {16'd0, m_block};  check("R3 rd", bus_rdata, w); end
            2'd2: begin w = 32'd0; w[20] = m_on; check("R4 rd", bus_rdata, w); end
            default: check("R8 rd", bus_rdata, 32'd0);
         endcase
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      v = bus_rdata;
   endtask

   task automatic set_req(input logic [15:0] r);
      @(negedge clk); #1;
      chan_req = r;
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check("R1 irq", {31'd0, irq_out}, 32'd0);
      rd(2'd1, v); check("R1 mask", v, 32'h0000FFFF);
      rd(2'd2, v); check("R1 en", v, 32'd0);

      // requests while all blocked and disabled
      set_req(16'h0005);
      rd(2'd0, v); check("R2 raw", v, 32'h00000005);
      settle(); check("R7 off", {31'd0, irq_out}, 32'd0);

      wr(2'd2, 32'h0010_0000);
      settle(); check("R5 blocked", {31'd0, irq_out}, 32'd0);

      wr(2'd1, 32'hFFFF_FFFE);
      rd(2'd1, v); check("R3 upper", v, 32'h0000FFFE);
      settle(); check("R6 open ch0", {31'd0, irq_out}, 32'd1);
      rd(2'd0, v); check("R2 raw masked", v, 32'h00000005);

      set_req(16'h0004);
      settle(); check("R5 ch2 blocked", {31'd0, irq_out}, 32'd0);
      wr(2'd1, 32'h0000_FFFB);
      settle(); check("R6 open ch2", {31'd0, irq_out}, 32'd1);

      wr(2'd2, 32'hFFEF_FFFF);
      rd(2'd2, v); check("R4 only bit20", v, 32'd0);
      settle(); check("R7 disabled", {31'd0, irq_out}, 32'd0);

      // writes to status and unused word
      wr(2'd0, 32'h0000_0000);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd1, v); check("R8 mask kept", v, 32'h0000FFFB);
      rd(2'd2, v); check("R8 en kept", v, 32'd0);
      rd(2'd3, v); check("R8 unused rd", v, 32'd0);

      wr(2'd2, 32'h0010_0000);
      rd(2'd2, v); check("R4 en set", v, 32'h0010_0000);

      // single-channel walk
      for (int ch = 0; ch < 16; ch++) begin
         wr(2'd1, {16'd0, ~(16'd1 << ch)});
         set_req(16'd1 << ch);
         settle(); check("R6 walk hit", {31'd0, irq_out}, 32'd1);
         set_req(16'd1 << ((ch + 1) % 16));
         settle(); check("R5 walk miss", {31'd0, irq_out}, 32'd0);
      end

      // all requests, all open, then reset again
      wr(2'd1, 32'd0);
      set_req(16'hFFFF);
      settle(); check("R6 all", {31'd0, irq_out}, 32'd1);
      @(negedge clk); #1 rst_n = 1'b0;
      @(negedge clk); @(negedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 re-reset irq", {31'd0, irq_out}, 32'd0);
      rd(2'd1, v); check("R1 re-reset mask", v, 32'h0000FFFF);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait (cyc > 20000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule